// File: doc/BRIEF.md
# Compare-Value System Timer

This block is a per-core deadline timer. A free-running 64-bit tick counter is shared by a set of identical timer channels; by default there are two, which can serve as a physical and a virtual timer over the same time base. Each channel holds a 64-bit absolute deadline and a small control word. It raises a level-sensitive interrupt once the counter has reached the deadline, as long as the channel is enabled and its output is not masked.

Software reaches the block through a synchronous 32-bit register port. It can set the deadline in two ways: as an absolute value written in two halves, or as a signed 32-bit offset from the current count. Reading the offset register gives the time left until the deadline, and that value turns negative once the deadline has passed. The expiry status stays readable while the output is masked, so software can poll for expiry without taking an interrupt. A read-only register reports the counter's tick rate, which lets software convert time into ticks.

Top module: `cvt_top`

## Requirements
- R1: After reset, every channel's enable and mask bits and its deadline are 0, the counter is 0, every interrupt output is low and read data is 0. Each clock after reset the counter goes up by exactly one.
- R2: A channel's condition is true when the counter, compared as an unsigned 64-bit number, is greater than or equal to the deadline. The condition is worked out again every cycle from the live values, so a deadline at or below the current count takes effect at once, and the condition is never true before the counter reaches the deadline. The status reads back as bit 2 of the control register.
- R3: When the enable bit is 0, the status bit reads 0 and the interrupt is low one cycle later.
- R4: The interrupt output is a register. In each cycle it shows (enable AND condition AND NOT mask) as evaluated in the cycle before.
- R5: The mask bit gates only the interrupt output. The status bit is still 1 while the mask bit is 1.
- R6: A write to the offset register sets the deadline to the counter value at the write edge plus the written word, sign-extended to 64 bits.
- R7: A read of the offset register returns the low 32 bits of (deadline minus counter), taken at the cycle the read is sampled.
- R8: The frequency register reads the constant FREQ_HZ.
- R9: Address bits [2:0] select the register: 0 = deadline bits 31:0, 1 = deadline bits 63:32, 2 = offset, 3 = control (bit 0 enable, bit 1 mask, bit 2 status, read-only), 4 = counter bits 31:0, 5 = counter bits 63:32, 6 = frequency. Registers 4 to 6 are shared by all channels and cannot be written.
- R10: The address bits above bit 2 select the channel. A write to one channel leaves every other channel's state and interrupt unchanged.
- R11: Read data is registered. It shows the addressed value from the cycle in which rd_en was high on the following cycle, and it holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | CH_W+3 | {channel, register select} |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
The bench watches the interrupt every cycle while a deadline set through the offset register runs out. A design that compared with strict greater-than, or that added the offset unsigned, would raise the line one cycle late or never. A deadline written below the current count, or as a negative offset, has to show status at once; a design that latched the status or waited for an exact match would stay quiet. The bench also checks that masking keeps the status visible but silences the line, that disabling clears both, that a nonzero upper deadline half keeps the channel idle, and that the offset reading crosses below zero.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    localparam int CNT_W     = 64;
    localparam int BUS_W     = 32;
    localparam int SEL_W     = 3;
    localparam int EXT_W     = CNT_W - BUS_W;
    localparam int STAT_POS  = 2;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [BUS_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        RS_DL_LO  = 3'd0,
        RS_DL_HI  = 3'd1,
        RS_OFFSET = 3'd2,
        RS_CTRL   = 3'd3,
        RS_CNT_LO = 3'd4,
        RS_CNT_HI = 3'd5,
        RS_FREQ   = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic  dl_lo;
        logic  dl_hi;
        logic  offset;
        logic  ctrl;
        word_t data;
    } chan_wr_t;

    function automatic count_t offset_deadline(count_t now, word_t ofs);
        return now + {{EXT_W{ofs[BUS_W-1]}}, ofs};
    endfunction

    function automatic word_t offset_view(count_t dl, count_t now);
        return dl[BUS_W-1:0] - now[BUS_W-1:0];
    endfunction

    function automatic word_t ctrl_word(ctrl_t c, logic stat);
        return {{(BUS_W-STAT_POS-1){1'b0}}, stat, c.mask, c.en};
    endfunction

endpackage

// File: rtl/cvt_counter.sv
module cvt_counter
    import cvt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output count_t cnt
);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + count_t'(1);
    end

endmodule

// File: rtl/cvt_channel.sv
module cvt_channel
    import cvt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  count_t   cnt,
    input  chan_wr_t wr,
    output count_t   dl,
    output ctrl_t    ctrl,
    output logic     stat,
    output logic     irq
);

    logic reached;

    assign reached = (cnt >= dl);
    assign stat    = ctrl.en & reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            dl   <= '0;
            ctrl <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= stat & ~ctrl.mask;
            if (wr.dl_lo)  dl[BUS_W-1:0]     <= wr.data;
            if (wr.dl_hi)  dl[CNT_W-1:BUS_W] <= wr.data;
            if (wr.offset) dl                <= offset_deadline(cnt, wr.data);
            if (wr.ctrl) begin
                ctrl.en   <= wr.data[0];
                ctrl.mask <= wr.data[1];
            end
        end
    end

endmodule

// File: rtl/cvt_regport.sv
module cvt_regport
    import cvt_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter int          CH_W    = 1,
    parameter logic [31:0] FREQ_HZ = 32'd50_000_000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [CH_W+SEL_W-1:0]   addr,
    input  word_t                   wdata,
    input  count_t                  cnt,
    input  count_t [NUM_CH-1:0]     dl_v,
    input  ctrl_t  [NUM_CH-1:0]     ctrl_v,
    input  logic   [NUM_CH-1:0]     stat_v,
    output chan_wr_t [NUM_CH-1:0]   wr_v,
    output word_t                   rd_data
);

    reg_sel_e          sel;
    logic [CH_W-1:0]   ch_idx;
    logic              ch_ok;
    word_t             rd_next;

    assign sel    = reg_sel_e'(addr[SEL_W-1:0]);
    assign ch_idx = addr[CH_W+SEL_W-1:SEL_W];
    assign ch_ok  = (int'(ch_idx) < NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic hit;
        assign hit             = wr_en && (int'(ch_idx) == g);
        assign wr_v[g].dl_lo   = hit && (sel == RS_DL_LO);
        assign wr_v[g].dl_hi   = hit && (sel == RS_DL_HI);
        assign wr_v[g].offset  = hit && (sel == RS_OFFSET);
        assign wr_v[g].ctrl    = hit && (sel == RS_CTRL);
        assign wr_v[g].data    = wdata;
    end

    always_comb begin
        rd_next = '0;
        case (sel)
            RS_CNT_LO: rd_next = cnt[BUS_W-1:0];
            RS_CNT_HI: rd_next = cnt[CNT_W-1:BUS_W];
            RS_FREQ:   rd_next = FREQ_HZ;
            RS_DL_LO:  if (ch_ok) rd_next = dl_v[ch_idx][BUS_W-1:0];
            RS_DL_HI:  if (ch_ok) rd_next = dl_v[ch_idx][CNT_W-1:BUS_W];
            RS_OFFSET: if (ch_ok) rd_next = offset_view(dl_v[ch_idx], cnt);
            RS_CTRL:   if (ch_ok) rd_next = ctrl_word(ctrl_v[ch_idx], stat_v[ch_idx]);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

endmodule

// File: rtl/cvt_top.sv
module cvt_top
    import cvt_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter logic [31:0] FREQ_HZ = 32'd50_000_000,
    localparam int         CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [CH_W+2:0]       addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rd_data,
    output logic [NUM_CH-1:0]     irq
);

    count_t                 cnt_q;
    count_t   [NUM_CH-1:0]  dl_v;
    ctrl_t    [NUM_CH-1:0]  ctrl_v;
    logic     [NUM_CH-1:0]  stat_v;
    logic     [NUM_CH-1:0]  en_v;
    logic     [NUM_CH-1:0]  mask_v;
    chan_wr_t [NUM_CH-1:0]  wr_v;

    cvt_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cvt_channel u_ch (
            .clk  (clk),
            .rst  (rst),
            .cnt  (cnt_q),
            .wr   (wr_v[g]),
            .dl   (dl_v[g]),
            .ctrl (ctrl_v[g]),
            .stat (stat_v[g]),
            .irq  (irq[g])
        );
        assign en_v[g]   = ctrl_v[g].en;
        assign mask_v[g] = ctrl_v[g].mask;
    end

    cvt_regport #(
        .NUM_CH  (NUM_CH),
        .CH_W    (CH_W),
        .FREQ_HZ (FREQ_HZ)
    ) u_port (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt_q),
        .dl_v    (dl_v),
        .ctrl_v  (ctrl_v),
        .stat_v  (stat_v),
        .wr_v    (wr_v),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/cvt_chk.sv
module cvt_chk #(
    parameter int NUM_CH = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [63:0]             cnt,
    input logic [NUM_CH-1:0][63:0] dl,
    input logic [NUM_CH-1:0]       en,
    input logic [NUM_CH-1:0]       mask,
    input logic [NUM_CH-1:0]       irq,
    input logic                    rd_en,
    input logic [31:0]             rd_data
);

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + 64'd1);

    p_read_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_p
        p_not_early_r2: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> $past(cnt >= dl[g]));

        p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
            !en[g] |=> !irq[g]);

        p_mask_quiet_r4: assert property (@(posedge clk) disable iff (rst)
            mask[g] |=> !irq[g]);
    end

endmodule

bind cvt_top cvt_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_q),
    .dl      (dl_v),
    .en      (en_v),
    .mask    (mask_v),
    .irq     (irq),
    .rd_en   (rd_en),
    .rd_data (rd_data)
);

// File: tb/sim_cvt_top.sv
module sim_cvt_top;

    localparam logic [31:0] FREQ = 32'd50_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cvt_top #(.NUM_CH(2), .FREQ_HZ(FREQ)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    // Reference model, advanced on the same edges as the design
    logic [63:0] tb_cnt;
    logic [63:0] m_dl [2];
    logic        m_en [2];
    logic        m_mask [2];
    logic [1:0]  exp_irq;
    logic        rd_pend;

    always @(posedge clk) begin
        if (rst) begin
            tb_cnt  <= '0;
            exp_irq <= '0;
            rd_pend <= 1'b0;
            for (int c = 0; c < 2; c++) begin
                m_dl[c] <= '0; m_en[c] <= 1'b0; m_mask[c] <= 1'b0;
            end
        end else begin
            tb_cnt  <= tb_cnt + 64'd1;
            rd_pend <= rd_en;
            for (int c = 0; c < 2; c++)
                exp_irq[c] <= m_en[c] && (tb_cnt >= m_dl[c]) && !m_mask[c];
            if (wr_en) begin
                case (addr[2:0])
                    3'd0: m_dl[addr[3]][31:0]  <= wdata;
                    3'd1: m_dl[addr[3]][63:32] <= wdata;
                    3'd2: m_dl[addr[3]] <= tb_cnt + {{32{wdata[31]}}, wdata};
                    3'd3: begin
                        m_en[addr[3]]   <= wdata[0];
                        m_mask[addr[3]] <= wdata[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [3:0] a);
        logic c;
        logic st;
        c  = a[3];
        st = m_en[c] && (tb_cnt >= m_dl[c]);
        case (a[2:0])
            3'd0: return m_dl[c][31:0];
            3'd1: return m_dl[c][63:32];
            3'd2: return m_dl[c][31:0] - tb_cnt[31:0];
            3'd3: return {29'd0, st, m_mask[c], m_en[c]};
            3'd4: return tb_cnt[31:0];
            3'd5: return tb_cnt[63:32];
            3'd6: return FREQ;
            default: return 32'd0;
        endcase
    endfunction

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // Monitor: read data appears one cycle after rd_en (R11)
    always @(negedge clk) begin
        if (!rst && rd_pend) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s R11 read: got %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic watch(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (irq !== exp_irq) begin
                fails++;
                $display("FAIL %s irq: got %b expected %b", tag, irq, exp_irq);
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        watch(1, "R1");
        rd(4'h3, "R1");
        rd(4'h0, "R1");
        rd(4'h4, "R9");
        rd(4'h5, "R9");
        rd(4'h6, "R8");
        // R2 far deadline: no status, no interrupt
        wr(4'h1, 32'd0);
        wr(4'h0, 32'd5000);
        wr(4'h3, 32'd1);
        watch(3, "R2");
        rd(4'h3, "R2");
        // R2 deadline below count: immediate; R10 channel 1 stays low
        wr(4'h0, 32'd2);
        watch(3, "R2_R10");
        rd(4'h3, "R2");
        // R5 mask keeps status, silences output
        wr(4'h3, 32'd3);
        watch(3, "R4");
        rd(4'h3, "R5");
        // R3 disable clears status and output
        wr(4'h3, 32'd0);
        watch(3, "R3");
        rd(4'h3, "R3");
        // R6 offset deadline, R7 offset readback
        wr(4'h2, 32'd40);
        rd(4'h0, "R6");
        rd(4'h2, "R7");
        wr(4'h3, 32'd1);
        watch(45, "R6");
        rd(4'h2, "R7");
        rd(4'h3, "R2");
        // R6 negative offset fires at once
        wr(4'h3, 32'd0);
        wr(4'h2, 32'hFFFF_FFFB);
        wr(4'h3, 32'd1);
        watch(3, "R6");
        rd(4'h3, "R6");
        rd(4'h1, "R6");
        // R2 nonzero upper half holds the channel idle
        wr(4'h1, 32'd1);
        watch(3, "R2");
        rd(4'h3, "R2");
        rd(4'h2, "R7");
        // R10 channel 1 on its own deadline
        wr(4'hB, 32'd0);
        wr(4'hA, 32'd12);
        wr(4'hB, 32'd1);
        watch(16, "R10");
        rd(4'hB, "R10");
        rd(4'h3, "R10");
        rd(4'h9, "R10");
        rd(4'h5, "R9");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule